// File: doc/BRIEF.md
# Register Rename and Issue Stage

This block sits between instruction decode and the reorder buffer of an out-of-order core. Each incoming instruction names architectural registers. The block translates its two sources through a map table from architectural to physical registers. When the instruction writes a register, the block takes a brand-new physical register from a pool of free register numbers and points the map entry at it. Every architectural write therefore lands in a register that has not been written yet, so write-after-read and write-after-write hazards cannot occur downstream.

The block also keeps a copy of every physical register value, with a ready flag for each one, and updates it by watching the result bus. At issue, a source that has already been produced goes out with its value and the ready flag set. A source that has not been produced goes out with the ready flag clear, and the reorder buffer catches it later from the bus. The commit stage sends the previous mapping of a retired destination back through a release port, and that register joins the free pool again.

The rename packet is registered and appears one cycle after the instruction is accepted. When an instruction needs a destination and the free pool is empty, the block raises `stall` and accepts nothing.

Top module: `rename_stage`

## Requirements
- R1: An accepted instruction with `in_has_dst`=1 receives the physical register at the head of the free pool as `out_dst_tag`. The map entry of `in_dst` then points at that register, so a later reader of `in_dst` gets this tag as its source tag.
- R2: Sources are translated through the map as it stood before the issuing instruction's own update, so an instruction whose source equals its destination reads the previous physical register.
- R3: `out_old_dst_tag` carries the physical register that `in_dst` mapped to just before the issuing instruction updated the map.
- R4: A result bus write (`bus_valid`=1) stores `bus_data` for `bus_tag`. A later source read of that tag returns the stored value with its ready flag at 1.
- R5: A source whose physical register has not been written goes out with its ready flag at 0 and its value field at 0.
- R6: Allocating a destination clears that physical register's ready flag, even if the register previously held a value.
- R7: When the bus writes a register in the same cycle that the register is read as a source, the source goes out with the bus value and its ready flag at 1.
- R8: `stall` is 1 exactly when `in_valid`=1, `in_has_dst`=1 and the free pool is empty. A stalled instruction is not issued and leaves the map unchanged. An instruction with no destination issues even when the pool is empty.
- R9: A release (`rel_valid`=1) appends `rel_tag` to the tail of the free pool. Allocation follows first-in first-out order, and after reset the first allocations are registers ARCH_REGS, ARCH_REGS+1, … PHYS_REGS-1 in ascending order.
- R10: After reset, architectural register i maps to physical register i, which is ready with value 0, and `out_valid` is 0.
- R11: `out_valid` is 1 in the cycle after each accepted instruction and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_src1 | input | AREG_W | First source, architectural register |
| in_src2 | input | AREG_W | Second source, architectural register |
| in_dst | input | AREG_W | Destination, architectural register |
| in_has_dst | input | 1 | Instruction writes `in_dst` |
| bus_valid | input | 1 | Result bus write present |
| bus_tag | input | TAG_W | Physical register being written |
| bus_data | input | DATA_W | Value being written |
| rel_valid | input | 1 | Release a physical register |
| rel_tag | input | TAG_W | Physical register to release |
| stall | output | 1 | Instruction held: no free register |
| out_valid | output | 1 | Rename packet valid |
| out_src1_tag | output | TAG_W | First source, physical register |
| out_src1_rdy | output | 1 | First source value is known |
| out_src1_val | output | DATA_W | First source value, or 0 |
| out_src2_tag | output | TAG_W | Second source, physical register |
| out_src2_rdy | output | 1 | Second source value is known |
| out_src2_val | output | DATA_W | Second source value, or 0 |
| out_has_dst | output | 1 | Packet has a destination |
| out_dst_tag | output | TAG_W | Newly allocated destination, or 0 |
| out_old_dst_tag | output | TAG_W | Previous mapping of the destination |

## Verification
Two pairs of functions can collide in a single cycle. In the first, a result bus write hits a register that the issuing instruction reads as a source. In the second, an allocation takes a register whose ready flag a previous broadcast had set. The bench provokes the first by driving the bus onto the tag of a pending source in the issue cycle, and checks that the packet carries the bus value as ready. It provokes the second by draining the pool, releasing a register that already holds a value, and allocating it again; the next reader of that register must see it as not ready. A reference model in the bench predicts each packet, and the actual packet is compared against it in the cycle after acceptance.

// File: rtl/rename_pkg.sv
// Package: default sizes shared by the rename stage, its parts and the bench.
// Assumes PHYS_REGS > ARCH_REGS so that the free pool starts non-empty.
package rename_pkg;
    parameter int ARCH_REGS_DEF = 16;
    parameter int PHYS_REGS_DEF = 32;
    parameter int DATA_W_DEF    = 32;
endpackage

// File: rtl/rename_map_table.sv
// Map table: architectural-to-physical translation with two source read
// ports, one read port for the old destination mapping and one write port.
// Reads are combinational and show the state before this cycle's write.
module rename_map_table #(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 32,
    localparam int AREG_W   = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREG_W-1:0] rd_a_idx,
    input  logic [AREG_W-1:0] rd_b_idx,
    input  logic [AREG_W-1:0] rd_d_idx,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [TAG_W-1:0]  rd_d_tag,
    input  logic              wr_en,
    input  logic [AREG_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag
);
    logic [TAG_W-1:0] map_q [ARCH_REGS];

    // Update one entry per cycle; reset to the identity mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                map_q[i] <= TAG_W'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_tag;
        end
    end

    // Read the current mappings.
    always_comb begin
        rd_a_tag = map_q[rd_a_idx];
        rd_b_tag = map_q[rd_b_idx];
        rd_d_tag = map_q[rd_d_idx];
    end
endmodule

// File: rtl/rename_free_list.sv
// Free pool: a circular FIFO of physical register numbers. Pop takes the
// head, and push appends to the tail. At reset it holds ARCH_REGS..PHYS_REGS-1
// in ascending order. Assumes the caller never pushes a register twice.
module rename_free_list #(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 32,
    localparam int TAG_W    = $clog2(PHYS_REGS),
    localparam int CNT_W    = $clog2(PHYS_REGS + 1),
    localparam int INIT_CNT = PHYS_REGS - ARCH_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] slot_q [PHYS_REGS];
    logic [TAG_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop, do_push;

    // Advance an index around the ring.
    function automatic logic [TAG_W-1:0] ring_next(input logic [TAG_W-1:0] p);
        return (int'(p) == PHYS_REGS - 1) ? '0 : p + 1'b1;
    endfunction

    // Gate the requests by occupancy.
    always_comb begin
        do_pop  = pop && (cnt_q != '0);
        do_push = push && (int'(cnt_q) < PHYS_REGS);
    end

    // Maintain the slots, the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                slot_q[i] <= (i < INIT_CNT) ? TAG_W'(ARCH_REGS + i) : '0;
            end
            head_q <= '0;
            tail_q <= TAG_W'(INIT_CNT);
            cnt_q  <= CNT_W'(INIT_CNT);
        end else begin
            if (do_push) begin
                slot_q[tail_q] <= push_tag;
                tail_q         <= ring_next(tail_q);
            end
            if (do_pop) begin
                head_q <= ring_next(head_q);
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Present the head and the occupancy.
    always_comb begin
        head_tag = slot_q[head_q];
        empty    = (cnt_q == '0);
        count    = cnt_q;
    end
endmodule

// File: rtl/rename_prf.sv
// Physical value file: one value and one ready flag per physical register.
// The result bus writes it. Allocation clears the ready flag, and allocation
// wins over a bus write to the same register. The two read ports forward a
// bus write of the same cycle.
module rename_prf #(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 32,
    parameter int DATA_W    = 32,
    localparam int TAG_W    = $clog2(PHYS_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              clr_en,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [TAG_W-1:0]  rd_a_tag,
    input  logic [TAG_W-1:0]  rd_b_tag,
    output logic              rd_a_rdy,
    output logic [DATA_W-1:0] rd_a_val,
    output logic              rd_b_rdy,
    output logic [DATA_W-1:0] rd_b_val
);
    logic [DATA_W-1:0] val_q [PHYS_REGS];
    logic [PHYS_REGS-1:0] rdy_q;

    // Record bus results and clear the ready flag on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                val_q[i] <= '0;
                rdy_q[i] <= (i < ARCH_REGS);
            end
        end else begin
            if (bus_valid) begin
                val_q[bus_tag] <= bus_data;
                rdy_q[bus_tag] <= 1'b1;
            end
            if (clr_en) begin
                rdy_q[clr_tag] <= 1'b0;
            end
        end
    end

    // Read with same-cycle bus forwarding; the value is 0 when not ready.
    always_comb begin
        if (bus_valid && bus_tag == rd_a_tag) begin
            rd_a_rdy = 1'b1;
            rd_a_val = bus_data;
        end else begin
            rd_a_rdy = rdy_q[rd_a_tag];
            rd_a_val = rdy_q[rd_a_tag] ? val_q[rd_a_tag] : '0;
        end
        if (bus_valid && bus_tag == rd_b_tag) begin
            rd_b_rdy = 1'b1;
            rd_b_val = bus_data;
        end else begin
            rd_b_rdy = rdy_q[rd_b_tag];
            rd_b_val = rdy_q[rd_b_tag] ? val_q[rd_b_tag] : '0;
        end
    end
endmodule

// File: rtl/rename_stage.sv
// Rename and issue stage: translates sources through the map table, takes a
// fresh destination from the free pool, fills in known source values from
// the physical value file and registers the rename packet. It stalls when a
// destination is needed and the pool is empty. Assumes the commit stage
// releases each register only once, and only after it has been retired.
module rename_stage
    import rename_pkg::*;
#(
    parameter int ARCH_REGS = ARCH_REGS_DEF,
    parameter int PHYS_REGS = PHYS_REGS_DEF,
    parameter int DATA_W    = DATA_W_DEF,
    localparam int AREG_W   = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(PHYS_REGS),
    localparam int CNT_W    = $clog2(PHYS_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [AREG_W-1:0] in_src1,
    input  logic [AREG_W-1:0] in_src2,
    input  logic [AREG_W-1:0] in_dst,
    input  logic              in_has_dst,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              rel_valid,
    input  logic [TAG_W-1:0]  rel_tag,
    output logic              stall,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_src1_tag,
    output logic              out_src1_rdy,
    output logic [DATA_W-1:0] out_src1_val,
    output logic [TAG_W-1:0]  out_src2_tag,
    output logic              out_src2_rdy,
    output logic [DATA_W-1:0] out_src2_val,
    output logic              out_has_dst,
    output logic [TAG_W-1:0]  out_dst_tag,
    output logic [TAG_W-1:0]  out_old_dst_tag
);
    logic              fire, alloc;
    logic              fl_empty;
    logic [CNT_W-1:0]  free_cnt;
    logic [TAG_W-1:0]  fl_head;
    logic [TAG_W-1:0]  s1_tag, s2_tag, old_tag;
    logic              s1_rdy, s2_rdy;
    logic [DATA_W-1:0] s1_val, s2_val;

    // Decide whether the instruction is accepted this cycle.
    always_comb begin
        stall = in_valid && in_has_dst && fl_empty;
        fire  = in_valid && !stall;
        alloc = fire && in_has_dst;
    end

    rename_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (in_src1),
        .rd_b_idx (in_src2),
        .rd_d_idx (in_dst),
        .rd_a_tag (s1_tag),
        .rd_b_tag (s2_tag),
        .rd_d_tag (old_tag),
        .wr_en    (alloc),
        .wr_idx   (in_dst),
        .wr_tag   (fl_head)
    );

    rename_free_list #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .head_tag (fl_head),
        .empty    (fl_empty),
        .count    (free_cnt)
    );

    rename_prf #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W)) u_prf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_data  (bus_data),
        .clr_en    (alloc),
        .clr_tag   (fl_head),
        .rd_a_tag  (s1_tag),
        .rd_b_tag  (s2_tag),
        .rd_a_rdy  (s1_rdy),
        .rd_a_val  (s1_val),
        .rd_b_rdy  (s2_rdy),
        .rd_b_val  (s2_val)
    );

    // Register the rename packet toward the reorder buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_src1_tag    <= '0;
            out_src1_rdy    <= 1'b0;
            out_src1_val    <= '0;
            out_src2_tag    <= '0;
            out_src2_rdy    <= 1'b0;
            out_src2_val    <= '0;
            out_has_dst     <= 1'b0;
            out_dst_tag     <= '0;
            out_old_dst_tag <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_src1_tag    <= s1_tag;
                out_src1_rdy    <= s1_rdy;
                out_src1_val    <= s1_val;
                out_src2_tag    <= s2_tag;
                out_src2_rdy    <= s2_rdy;
                out_src2_val    <= s2_val;
                out_has_dst     <= in_has_dst;
                out_dst_tag     <= in_has_dst ? fl_head : '0;
                out_old_dst_tag <= old_tag;
            end
        end
    end
endmodule

// File: rtl/rename_stage_chk.sv
// Checker for rename_stage: temporal properties over its ports and the
// free pool occupancy. It is attached to every instance by the bind below.
module rename_stage_chk #(
    parameter int ARCH_REGS = 16,
    parameter int PHYS_REGS = 32,
    parameter int DATA_W    = 32,
    localparam int TAG_W    = $clog2(PHYS_REGS),
    localparam int CNT_W    = $clog2(PHYS_REGS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_has_dst,
    input logic              stall,
    input logic              out_valid,
    input logic              out_has_dst,
    input logic [TAG_W-1:0]  out_src1_tag,
    input logic [TAG_W-1:0]  out_src2_tag,
    input logic [TAG_W-1:0]  out_dst_tag,
    input logic [TAG_W-1:0]  out_old_dst_tag,
    input logic              out_src1_rdy,
    input logic [DATA_W-1:0] out_src1_val,
    input logic              out_src2_rdy,
    input logic [DATA_W-1:0] out_src2_val,
    input logic [CNT_W-1:0]  free_cnt
);
    // R8: a stall occurs only with an empty pool and a destination request.
    a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (free_cnt == '0) && in_has_dst);

    // R8: a stalled instruction produces no packet.
    a_r8_stall_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !out_valid);

    // R1: a fresh destination differs from the sources and the old mapping.
    a_r1_dst_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_has_dst |-> (out_dst_tag != out_src1_tag) &&
        (out_dst_tag != out_src2_tag) && (out_dst_tag != out_old_dst_tag));

    // R5: a source that is not ready carries a zero value.
    a_r5_unready_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_src1_rdy || out_src1_val == '0) &&
        (out_src2_rdy || out_src2_val == '0));

    // R9: the pool never holds more registers than exist outside the map.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= PHYS_REGS - ARCH_REGS);

    // R11: a packet follows an instruction presented in the previous cycle.
    a_r11_packet_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

bind rename_stage rename_stage_chk #(
    .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_has_dst      (in_has_dst),
    .stall           (stall),
    .out_valid       (out_valid),
    .out_has_dst     (out_has_dst),
    .out_src1_tag    (out_src1_tag),
    .out_src2_tag    (out_src2_tag),
    .out_dst_tag     (out_dst_tag),
    .out_old_dst_tag (out_old_dst_tag),
    .out_src1_rdy    (out_src1_rdy),
    .out_src1_val    (out_src1_val),
    .out_src2_rdy    (out_src2_rdy),
    .out_src2_val    (out_src2_val),
    .free_cnt        (free_cnt)
);

// File: tb/tb_rename_stage.sv
// Scoreboard bench: the driver predicts each packet from a reference model
// and queues it; the monitor compares it in the cycle after acceptance.
module tb_rename_stage;
    localparam int ARCH = 16;
    localparam int PHYS = 32;
    localparam int DW   = 32;
    localparam int AW   = $clog2(ARCH);
    localparam int TW   = $clog2(PHYS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_has_dst = 1'b0;
    logic [AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [DW-1:0] bus_data = '0;
    logic          rel_valid = 1'b0;
    logic [TW-1:0] rel_tag = '0;
    logic          stall, out_valid, out_src1_rdy, out_src2_rdy, out_has_dst;
    logic [TW-1:0] out_src1_tag, out_src2_tag, out_dst_tag, out_old_dst_tag;
    logic [DW-1:0] out_src1_val, out_src2_val;

    always #10 clk = ~clk;

    rename_stage #(.ARCH_REGS(ARCH), .PHYS_REGS(PHYS), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src1(in_src1),
        .in_src2(in_src2), .in_dst(in_dst), .in_has_dst(in_has_dst),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .rel_valid(rel_valid), .rel_tag(rel_tag), .stall(stall),
        .out_valid(out_valid), .out_src1_tag(out_src1_tag),
        .out_src1_rdy(out_src1_rdy), .out_src1_val(out_src1_val),
        .out_src2_tag(out_src2_tag), .out_src2_rdy(out_src2_rdy),
        .out_src2_val(out_src2_val), .out_has_dst(out_has_dst),
        .out_dst_tag(out_dst_tag), .out_old_dst_tag(out_old_dst_tag)
    );

    typedef struct {
        int    s1t, s1r, s2t, s2r, hd, dt, old;
        longint s1v, s2v;
        string  req;
    } pkt_t;

    int     total = 0, bad = 0;
    pkt_t   expq[$];
    int     m_map [ARCH];
    int     m_rdy [PHYS];
    longint m_val [PHYS];
    int     m_free[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at the falling edge, predict, advance the model.
    task automatic cycle(input bit iv, input int s1, input int s2, input int d,
                         input bit hd, input bit bv, input int bt, input longint bd,
                         input bit rv, input int rt, input string req);
        bit   exp_stall;
        pkt_t p;
        @(negedge clk);
        in_valid = iv; in_src1 = AW'(s1); in_src2 = AW'(s2); in_dst = AW'(d);
        in_has_dst = hd; bus_valid = bv; bus_tag = TW'(bt); bus_data = DW'(bd);
        rel_valid = rv; rel_tag = TW'(rt);
        #1;
        exp_stall = iv && hd && (m_free.size() == 0);
        check(stall == exp_stall, req, "stall", longint'(stall), longint'(exp_stall));
        if (iv && !exp_stall) begin
            p.req = req;
            p.s1t = m_map[s1];
            p.s1r = (bv && bt == p.s1t) ? 1 : m_rdy[p.s1t];
            p.s1v = (bv && bt == p.s1t) ? bd : (m_rdy[p.s1t] != 0 ? m_val[p.s1t] : 0);
            p.s2t = m_map[s2];
            p.s2r = (bv && bt == p.s2t) ? 1 : m_rdy[p.s2t];
            p.s2v = (bv && bt == p.s2t) ? bd : (m_rdy[p.s2t] != 0 ? m_val[p.s2t] : 0);
            p.hd  = hd;
            p.old = m_map[d];
            p.dt  = hd ? m_free.pop_front() : 0;
            expq.push_back(p);
        end
        if (bv) begin
            m_rdy[bt] = 1;
            m_val[bt] = bd;
        end
        if (iv && !exp_stall && hd) begin
            m_rdy[p.dt] = 0;
            m_map[d]    = p.dt;
        end
        if (rv) m_free.push_back(rt);
        @(posedge clk);
    endtask

    task automatic idle();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    endtask

    // Monitor: compare each packet in the cycle after acceptance (R11).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(0, "R11", "unexpected packet", 1, 0);
                end else begin
                    pkt_t e;
                    e = expq.pop_front();
                    check(int'(out_src1_tag) == e.s1t, e.req, "src1 tag", longint'(out_src1_tag), e.s1t);
                    check(int'(out_src1_rdy) == e.s1r, e.req, "src1 rdy", longint'(out_src1_rdy), e.s1r);
                    check(longint'(out_src1_val) == e.s1v, e.req, "src1 val", longint'(out_src1_val), e.s1v);
                    check(int'(out_src2_tag) == e.s2t, e.req, "src2 tag", longint'(out_src2_tag), e.s2t);
                    check(int'(out_src2_rdy) == e.s2r, e.req, "src2 rdy", longint'(out_src2_rdy), e.s2r);
                    check(longint'(out_src2_val) == e.s2v, e.req, "src2 val", longint'(out_src2_val), e.s2v);
                    check(int'(out_has_dst) == e.hd, e.req, "has dst", longint'(out_has_dst), e.hd);
                    check(int'(out_dst_tag) == e.dt, e.req, "dst tag", longint'(out_dst_tag), e.dt);
                    check(int'(out_old_dst_tag) == e.old, e.req, "old dst tag", longint'(out_old_dst_tag), e.old);
                end
            end else if (expq.size() != 0) begin
                check(0, "R11", "missing packet", 0, 1);
                void'(expq.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        check(0, "R11", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < ARCH; i++) m_map[i] = i;
        for (int i = 0; i < PHYS; i++) begin
            m_rdy[i] = (i < ARCH) ? 1 : 0;
            m_val[i] = 0;
        end
        for (int i = ARCH; i < PHYS; i++) m_free.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state at the ports.
        check(out_valid == 1'b0, "R10", "out_valid after reset", longint'(out_valid), 0);
        check(stall == 1'b0, "R10", "stall after reset", longint'(stall), 0);
        // R10: identity map, ready with zero value.
        cycle(1, 3, 9, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R4: a bus write, then a reader of that register.
        cycle(0, 0, 0, 0, 0, 1, 5, 'h55, 0, 0, "R4");
        cycle(1, 5, 2, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R1 R2 R3: the source equals the destination.
        cycle(1, 3, 3, 3, 1, 0, 0, 0, 0, 0, "R1 R2 R3");
        // R5: a reader of an unwritten new register.
        cycle(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R7: the bus writes tag 16 in the issue cycle.
        cycle(1, 3, 3, 0, 0, 1, 16, 'h77, 0, 0, "R7");
        cycle(1, 4, 3, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R9: drain the pool in first-in first-out order.
        for (int k = 0; k < PHYS - ARCH - 1; k++) begin
            cycle(1, (k + 1) % ARCH, k % ARCH, (k + 5) % ARCH, 1, 0, 0, 0, 0, 0, "R9");
        end
        idle();
        // R8: empty pool stalls a writer; a non-writer still issues.
        cycle(1, 2, 2, 7, 1, 0, 0, 0, 0, 0, "R8");
        cycle(1, 7, 7, 7, 0, 0, 0, 0, 0, 0, "R8");
        idle();
        // R9 R6: release register 3 (holds a value), then register 20.
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, "R9");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 20, "R9");
        cycle(1, 6, 6, 7, 1, 0, 0, 0, 0, 0, "R6 R9");
        cycle(1, 7, 6, 2, 1, 0, 0, 0, 0, 0, "R6 R9");
        // R8: the pool is empty again, with a release in the same cycle.
        cycle(1, 1, 1, 1, 1, 0, 0, 0, 1, 16, "R8");
        cycle(1, 1, 2, 1, 1, 0, 0, 0, 0, 0, "R8 R9");
        idle();
        idle();
        check(expq.size() == 0, "R11", "queue drained", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule